// File: doc/BRIEF.md
# Local Peripheral Bus Strobe Timer

This block drives the control strobes for a single read or write cycle on a byte-wide local peripheral bus. The host side gives a one-clock start pulse when its data phase opens. The block fixes a reference cycle two clocks later. Every strobe edge is then placed at its own programmable 4-bit count of clocks after that reference. One block serves both bus families. In Intel style it drives a chip select, a read strobe and a write strobe. In Motorola style the select lines carry data strobes and the write-strobe pin carries read-not-write.

At the start pulse the block samples the timing counts, the direction, the bus style and the 2-bit select index. Changing any of them during a cycle has no effect. A data-output-enable flag tells the external transceivers which way to drive the data lines. A done pulse closes the cycle. Address decoding and the host-bus handshake belong to the surrounding logic.

Top module: `lbus_strobe_timer`

## Requirements
- R1: When `start` is sampled high while idle at clock edge E0, the reference point is edge E0+2. A strobe whose assert count is a goes low in the cycle that begins at edge E0+2+a.
- R2: A strobe with deassert count d (d > a) returns high in the cycle that begins at edge E0+2+d.
- R3: In Intel style, `cs_n[cs_sel]` is the only select line that moves. It is timed by the read chip-select pair (`t_rcs_on`/`t_rcs_off`) on reads and by the write pair (`t_wcs_on`/`t_wcs_off`) on writes. The other select lines stay high.
- R4: In Intel style, `rd_n` follows the read-strobe pair on reads and `wr_n` follows the write-strobe pair on writes. The strobe for the other direction stays high.
- R5: In Motorola style (`moto_style`=1), `cs_n[cs_sel]` acts as the data strobe, timed by the read-strobe pair on reads and the write-strobe pair on writes. `wr_n` acts as read-not-write: it is low on writes across the write chip-select window and high on reads. `rd_n` stays high and `rd_oe` is 0 (pin released). In Intel style `rd_oe` is 1.
- R6: `dout_en` is 1 from the cycle after E0 through the last busy cycle of a write, and 0 throughout a read.
- R7: Let L be the largest effective deassert count among the two pairs in use. `done` is high for exactly one clock, in the cycle that begins at edge E0+2+L+1. The block is idle again from that cycle on.
- R8: Any count from 11 to 15 acts as 10.
- R9: When a deassert count is not greater than its assert count, after saturation, that strobe is low for exactly one clock, starting at its assert time.
- R10: A `start` pulse during a busy cycle is ignored. Timing counts, direction, style and index are taken only at the accepted start, so later changes to them do not alter the running cycle.
- R11: While `rst_n` is low, the block is idle: all `cs_n`, `rd_n` and `wr_n` are high, `done` and `dout_en` are 0, and `rd_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host data phase has begun (one-clock pulse) |
| wr_req | input | 1 | 1 = write cycle, 0 = read cycle |
| moto_style | input | 1 | 0 = Intel style, 1 = Motorola style |
| cs_sel | input | 2 | Index of the peripheral select line to use |
| t_rcs_on | input | 4 | Read chip-select assert count |
| t_rcs_off | input | 4 | Read chip-select deassert count |
| t_wcs_on | input | 4 | Write chip-select (Motorola: read-not-write) assert count |
| t_wcs_off | input | 4 | Write chip-select (Motorola: read-not-write) deassert count |
| t_rd_on | input | 4 | Read strobe / read data strobe assert count |
| t_rd_off | input | 4 | Read strobe / read data strobe deassert count |
| t_wr_on | input | 4 | Write strobe / write data strobe assert count |
| t_wr_off | input | 4 | Write strobe / write data strobe deassert count |
| cs_n | output | 4 | Active-low chip selects (Motorola: data strobes) |
| rd_n | output | 1 | Active-low read strobe, Intel style only |
| rd_oe | output | 1 | Drive enable for `rd_n`; 0 means the pin is high impedance |
| wr_n | output | 1 | Active-low write strobe (Motorola: read-not-write) |
| dout_en | output | 1 | 1 while the local data lines are driven outward |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench targets the off-by-one positions around the reference point. A design that counted from the start edge, or that registered the strobes one stage too many, would move every edge by a clock and miss the per-cycle compare. Reserved counts of 11 to 15 and reversed or equal assert/deassert pairs are driven directly. A design that let a count wrap, or that produced a zero-width strobe, would either stretch the cycle or drop the strobe entirely. A second start pulse and changed timing inputs arrive mid-cycle. A design that sampled its settings live would reshape the running cycle. Reset is also applied mid-cycle to catch strobes that stay low.

// File: rtl/lbst_pkg.sv
package lbst_pkg;

  typedef enum logic {
    BUS_INTEL = 1'b0,
    BUS_MOTO  = 1'b1
  } bus_style_e;

  // Reserved counts above the limit behave as the limit.
  function automatic int unsigned clamp_cnt(input int unsigned raw, input int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // First count at which a strobe is inactive again; at least one clock wide.
  function automatic int unsigned window_end(input int unsigned on_c, input int unsigned off_c,
                                             input int unsigned lim);
    int unsigned a;
    int unsigned d;
    a = clamp_cnt(on_c, lim);
    d = clamp_cnt(off_c, lim);
    return (d > a) ? d : a + 1;
  endfunction

endpackage

// File: rtl/lbst_sequencer.sv
module lbst_sequencer #(
  parameter int MAX_CNT = 10,
  parameter int REF_DLY = 2,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] last_end,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          step_vld,
  output logic [CW-1:0] step
);

  localparam logic [CW-1:0] LEAD = CW'(REF_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          finish;

  assign accept   = start && !busy_q;
  assign step_vld = busy_q && (cnt_q >= LEAD);
  assign step     = cnt_q - LEAD;
  assign finish   = step_vld && (step == last_end + CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CW'(1);
      busy_q <= !finish;
      done_q <= finish;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R7
  done_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy));
  // R7
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);

endmodule

// File: rtl/lbst_window.sv
module lbst_window #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 10,
  parameter int CW      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] on_raw,
  input  logic [CNT_W-1:0] off_raw,
  input  logic             step_vld,
  input  logic [CW-1:0]    step,
  output logic [CW-1:0]    win_end,
  output logic             act
);

  logic [CW-1:0] on_e;
  logic          act_next;
  logic          act_q;

  assign on_e    = CW'(lbst_pkg::clamp_cnt(int'(on_raw), MAX_CNT));
  assign win_end = CW'(lbst_pkg::window_end(int'(on_raw), int'(off_raw), MAX_CNT));
  assign act_next = step_vld && (step >= on_e) && (step < win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_next;
  end

  assign act = act_q;

  // R8
  end_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n) win_end <= CW'(MAX_CNT + 1));
  // R9
  act_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(act) |-> $past(step_vld));

endmodule

// File: rtl/lbus_strobe_timer.sv
module lbus_strobe_timer #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 10,
  parameter int NUM_CS  = 4,
  parameter int REF_DLY = 2,
  localparam int IDX_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_req,
  input  logic              moto_style,
  input  logic [IDX_W-1:0]  cs_sel,
  input  logic [CNT_W-1:0]  t_rcs_on,
  input  logic [CNT_W-1:0]  t_rcs_off,
  input  logic [CNT_W-1:0]  t_wcs_on,
  input  logic [CNT_W-1:0]  t_wcs_off,
  input  logic [CNT_W-1:0]  t_rd_on,
  input  logic [CNT_W-1:0]  t_rd_off,
  input  logic [CNT_W-1:0]  t_wr_on,
  input  logic [CNT_W-1:0]  t_wr_off,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              wr_n,
  output logic              dout_en,
  output logic              done
);

  import lbst_pkg::*;

  localparam int CW = $clog2(MAX_CNT + REF_DLY + 4) + 1;

  // Snapshot taken at the accepted start
  logic             wr_q;
  bus_style_e       style_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cs_on_q, cs_off_q, st_on_q, st_off_q;

  logic          busy, accept, step_vld;
  logic [CW-1:0] step;
  logic [CW-1:0] cs_end, st_end, last_end;
  logic          cs_act, st_act;
  logic          sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      style_q  <= BUS_INTEL;
      idx_q    <= '0;
      cs_on_q  <= '0;
      cs_off_q <= '0;
      st_on_q  <= '0;
      st_off_q <= '0;
    end else if (accept) begin
      wr_q     <= wr_req;
      style_q  <= bus_style_e'(moto_style);
      idx_q    <= cs_sel;
      cs_on_q  <= wr_req ? t_wcs_on  : t_rcs_on;
      cs_off_q <= wr_req ? t_wcs_off : t_rcs_off;
      st_on_q  <= wr_req ? t_wr_on   : t_rd_on;
      st_off_q <= wr_req ? t_wr_off  : t_rd_off;
    end
  end

  assign last_end = (cs_end > st_end) ? cs_end : st_end;

  lbst_sequencer #(.MAX_CNT(MAX_CNT), .REF_DLY(REF_DLY), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .last_end(last_end),
    .busy(busy), .done(done), .accept(accept), .step_vld(step_vld), .step(step)
  );

  lbst_window #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .CW(CW)) u_cs_win (
    .clk(clk), .rst_n(rst_n), .on_raw(cs_on_q), .off_raw(cs_off_q),
    .step_vld(step_vld), .step(step), .win_end(cs_end), .act(cs_act)
  );

  lbst_window #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .CW(CW)) u_st_win (
    .clk(clk), .rst_n(rst_n), .on_raw(st_on_q), .off_raw(st_off_q),
    .step_vld(step_vld), .step(step), .win_end(st_end), .act(st_act)
  );

  // Pin routing per bus style
  assign sel_act = (style_q == BUS_MOTO) ? st_act : cs_act;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign cs_n[g] = !(sel_act && (idx_q == IDX_W'(g)));
  end

  always_comb begin
    if (style_q == BUS_MOTO) begin
      rd_n  = 1'b1;
      rd_oe = 1'b0;
      wr_n  = !(wr_q && cs_act);
    end else begin
      rd_n  = !(st_act && !wr_q);
      rd_oe = 1'b1;
      wr_n  = !(st_act && wr_q);
    end
  end

  assign dout_en = busy && wr_q;

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R4
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R5
  moto_rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_oe |-> rd_n);
  // R6
  no_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !dout_en);
  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(wr_q) && $stable(idx_q) && $stable(st_off_q) && $stable(cs_off_q)));
  // R11
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !done) |-> (&cs_n && rd_n));

endmodule

// File: tb/lbus_strobe_timer_bench.sv
module lbus_strobe_timer_bench;

  typedef struct packed {
    bit moto; bit wr; bit [1:0] idx;
    bit [3:0] rcs_on; bit [3:0] rcs_off; bit [3:0] wcs_on; bit [3:0] wcs_off;
    bit [3:0] rd_on;  bit [3:0] rd_off;  bit [3:0] wr_on;  bit [3:0] wr_off;
    bit [7:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{0,0,2'd0, 4'd0,4'd3, 4'd0,4'd2, 4'd0,4'd3, 4'd0,4'd2, 8'd1},
    '{0,1,2'd1, 4'd0,4'd3, 4'd0,4'd2, 4'd0,4'd3, 4'd0,4'd2, 8'd3},
    '{0,0,2'd2, 4'd1,4'd5, 4'd0,4'd1, 4'd2,4'd4, 4'd0,4'd1, 8'd2},
    '{0,1,2'd3, 4'd0,4'd1, 4'd0,4'd7, 4'd0,4'd1, 4'd3,4'd6, 8'd4},
    '{1,0,2'd0, 4'd0,4'd9, 4'd0,4'd9, 4'd1,4'd4, 4'd0,4'd9, 8'd5},
    '{1,1,2'd2, 4'd0,4'd9, 4'd0,4'd6, 4'd0,4'd9, 4'd2,4'd5, 8'd5},
    '{0,0,2'd1, 4'd12,4'd3, 4'd0,4'd0, 4'd2,4'd15, 4'd0,4'd0, 8'd8},
    '{0,1,2'd0, 4'd0,4'd0, 4'd7,4'd3, 4'd0,4'd0, 4'd5,4'd5, 8'd9},
    '{1,1,2'd3, 4'd0,4'd0, 4'd0,4'd2, 4'd0,4'd0, 4'd14,4'd2, 8'd9},
    '{0,1,2'd2, 4'd0,4'd0, 4'd0,4'd0, 4'd0,4'd0, 4'd0,4'd0, 8'd9},
    '{0,1,2'd1, 4'd0,4'd0, 4'd1,4'd4, 4'd0,4'd0, 4'd0,4'd8, 8'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_req = 1'b0, moto_style = 1'b0;
  logic [1:0] cs_sel = '0;
  logic [3:0] t_rcs_on = '0, t_rcs_off = '0, t_wcs_on = '0, t_wcs_off = '0;
  logic [3:0] t_rd_on = '0, t_rd_off = '0, t_wr_on = '0, t_wr_off = '0;
  logic [3:0] cs_n;
  logic rd_n, rd_oe, wr_n, dout_en, done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lbus_strobe_timer u_lbus_strobe_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_req(wr_req), .moto_style(moto_style),
    .cs_sel(cs_sel), .t_rcs_on(t_rcs_on), .t_rcs_off(t_rcs_off), .t_wcs_on(t_wcs_on),
    .t_wcs_off(t_wcs_off), .t_rd_on(t_rd_on), .t_rd_off(t_rd_off), .t_wr_on(t_wr_on),
    .t_wr_off(t_wr_off), .cs_n(cs_n), .rd_n(rd_n), .rd_oe(rd_oe), .wr_n(wr_n),
    .dout_en(dout_en), .done(done)
  );

  function automatic string tag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic int sat10(input int x);
    if (x >= 10) return 10;
    return x;
  endfunction

  function automatic int stop_at(input int a, input int d);
    if (sat10(d) <= sat10(a)) return sat10(a) + 1;
    return sat10(d);
  endfunction

  // Longest effective deassert count of the pairs used (R7)
  function automatic int last_of(input vec_t v);
    int ec, es;
    ec = v.wr ? stop_at(v.wcs_on, v.wcs_off) : stop_at(v.rcs_on, v.rcs_off);
    es = v.wr ? stop_at(v.wr_on, v.wr_off)   : stop_at(v.rd_on, v.rd_off);
    return (ec > es) ? ec : es;
  endfunction

  // Expected {cs_n, rd_n, wr_n, rd_oe, dout_en, done} in the cycle after edge E0+j
  function automatic logic [8:0] model(input vec_t v, input int j);
    int k, L;
    bit c_on, s_on;
    logic [3:0] cs;
    logic r, w, oe;
    k = j - 2;
    L = last_of(v);
    if (v.wr) begin
      c_on = (k >= sat10(v.wcs_on)) && (k < stop_at(v.wcs_on, v.wcs_off));
      s_on = (k >= sat10(v.wr_on))  && (k < stop_at(v.wr_on, v.wr_off));
    end else begin
      c_on = (k >= sat10(v.rcs_on)) && (k < stop_at(v.rcs_on, v.rcs_off));
      s_on = (k >= sat10(v.rd_on))  && (k < stop_at(v.rd_on, v.rd_off));
    end
    cs = 4'hF;
    if (v.moto) begin
      cs[v.idx] = !s_on; r = 1'b1; oe = 1'b0; w = !(v.wr && c_on);
    end else begin
      cs[v.idx] = !c_on; r = !(s_on && !v.wr); oe = 1'b1; w = !(s_on && v.wr);
    end
    return {cs, r, w, oe, (v.wr && j <= L + 2), (j == L + 3)};
  endfunction

  function automatic logic [8:0] outs();
    return {cs_n, rd_n, wr_n, rd_oe, dout_en, done};
  endfunction

  task automatic check(input logic [8:0] exp, input int r, input string what);
    n_checks++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag(r), what, outs(), exp);
    end
  endtask

  task automatic apply(input vec_t v);
    wr_req = v.wr; moto_style = v.moto; cs_sel = v.idx;
    t_rcs_on = v.rcs_on; t_rcs_off = v.rcs_off; t_wcs_on = v.wcs_on; t_wcs_off = v.wcs_off;
    t_rd_on = v.rd_on; t_rd_off = v.rd_off; t_wr_on = v.wr_on; t_wr_off = v.wr_off;
  endtask

  // disturb: restart and alter settings while busy (R10)
  task automatic run(input vec_t v, input int r, input bit disturb);
    int L;
    L = last_of(v);
    @(negedge clk); apply(v); start = 1'b1;
    for (int j = 0; j <= L + 4; j++) begin
      if (j > 0) begin
        @(negedge clk);
        start = 1'b0;
        if (disturb && j == 2) begin
          apply(VECS[3]); moto_style = 1'b1; start = 1'b1;
        end
      end
      @(posedge clk); #1;
      check(model(v, j), r, $sformatf("cycle %0d (done also R7)", j));
    end
  endtask

  initial begin
    #1;
    check(9'b1111_1_1_1_0_0, 11, "reset idle (R11)");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run(VECS[i], int'(VECS[i].req), 1'b0);
    // R10: second start and changed settings while busy
    run(VECS[0], 10, 1'b1);
    // R11: reset in the middle of a write cycle
    @(negedge clk); apply(VECS[3]); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b0; #1;
    check(9'b1111_1_1_1_0_0, 11, "mid-cycle reset (R11)");
    @(negedge clk); rst_n = 1'b1;
    // R7: back-to-back after reset still times from the reference point
    run(VECS[1], 7, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R7 watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule